// File: doc/BRIEF.md
# Twisted-Ring Divider with One-Hot Slot Outputs

This block divides its clock by an even modulus set by the number of ring stages. Five stages give a divide-by-10 counter and four stages give a divide-by-8 counter. The count is held as a twisted-ring code: on each step, the inverted top stage is shifted in at the bottom. Starting from all zeros, five stages walk through 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 and then wrap.

Each ring state is decoded into one slot line. Every slot is formed from two neighbouring ring bits. The slot lines and a square-wave carry come straight from flip-flops, so no decoding glitch reaches a pin. The carry completes one period per full count, so it can clock or enable a following counter.

Counting is gated by an active-low enable. A high reset clears the counter at once, without waiting for a clock edge. Any ring pattern outside the legal sequence is replaced by the zero code on the next enabled step.

Top module: `johnson_divider`

## Requirements
- R1: The parameter STAGES sets the ring length. The block drives 2*STAGES slot lines. A full count takes 2*STAGES enabled clock edges (10 when STAGES=5, 8 when STAGES=4).
- R2: While `rst` is 1, the block is forced to slot 0 (`slot_o` = 1, `carry_o` = 1) without waiting for a clock edge, whatever `count_en_n` is. After release, slot 0 stays active until the first enabled edge.
- R3: On a rising edge with `count_en_n` = 1, neither `slot_o` nor `carry_o` changes.
- R4: Exactly one bit of `slot_o` is 1 at all times.
- R5: Each rising edge with `count_en_n` = 0 moves the active slot from bit k to bit k+1. The highest bit moves to bit 0. Each slot is therefore high for exactly one enabled cycle.
- R6: `carry_o` is 1 while slots 0 to STAGES-1 are active and 0 in the upper half. It rises only on the step into slot 0.
- R7: From any ring pattern, legal or not, the next-state logic reaches a legal twisted-ring code within 2*STAGES steps. A legal code always advances to the next code in the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on the rising edge |
| rst | input | 1 | Asynchronous clear, active high |
| count_en_n | input | 1 | Count enable, active low; 1 holds the count |
| slot_o | output | 2*STAGES | One-hot registered slot lines, bit k = count k |
| carry_o | output | 1 | Registered carry, high in the lower half of the count |

## Verification
The clocked properties assume two things about the inputs. First, `rst`, once raised, is held across at least one rising edge. Second, `count_en_n` is stable around each rising edge. Under these conditions, the value one cycle back is always a state the counter actually held. The stimulus meets both conditions by changing every input on the falling edge and by holding each reset pulse through a full cycle. Random enable patterns are mixed with long runs of counting and holding. The correction logic is exercised separately, in a standalone instance, with every ring pattern as input.

// File: rtl/johnson_pkg.sv
package johnson_pkg;
  localparam int unsigned MAX_STAGES = 8;

  typedef logic [MAX_STAGES-1:0] ring_word_t;

  // A legal twisted-ring code has at most one boundary between neighbours
  // among its lowest n bits.
  function automatic logic code_is_legal(input ring_word_t w, input int unsigned n);
    int unsigned edges;
    edges = 0;
    for (int unsigned i = 0; i < MAX_STAGES - 1; i++) begin
      if ((i + 1 < n) && (w[i] != w[i+1])) edges = edges + 1;
    end
    return (edges <= 1);
  endfunction
endpackage

// File: rtl/johnson_ring_step.sv
module johnson_ring_step
  import johnson_pkg::*;
#(
  parameter int unsigned STAGES = 5
) (
  input  logic [STAGES-1:0] ring_q,
  output logic [STAGES-1:0] ring_d
);
  ring_word_t wide;
  logic       legal;
  logic [STAGES-1:0] shifted;

  always_comb begin
    wide = '0;
    wide[STAGES-1:0] = ring_q;
  end

  assign legal   = code_is_legal(wide, STAGES);
  assign shifted = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
  // correction term: an illegal pattern collapses to the zero code
  assign ring_d  = legal ? shifted : '0;
endmodule

// File: rtl/johnson_slot_decode.sv
module johnson_slot_decode #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned SLOTS = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  output logic [SLOTS-1:0]  slots
);
  genvar k;
  generate
    for (k = 0; k < SLOTS; k++) begin : g_slot
      if (k == 0) begin : g_zero
        assign slots[k] = ~ring[STAGES-1] & ~ring[0];
      end else if (k < STAGES) begin : g_fill
        assign slots[k] = ring[k-1] & ~ring[k];
      end else if (k == STAGES) begin : g_full
        assign slots[k] = ring[STAGES-1] & ring[0];
      end else begin : g_drain
        assign slots[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
      end
    end
  endgenerate
endmodule

// File: rtl/johnson_divider.sv
module johnson_divider #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned SLOTS = 2 * STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en_n,
  output logic [SLOTS-1:0] slot_o,
  output logic             carry_o
);
  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_d;
  logic [SLOTS-1:0]  slot_d;

  johnson_ring_step #(.STAGES(STAGES)) u_step (
    .ring_q (ring_q),
    .ring_d (ring_d)
  );

  // decode the next state so slot flops switch together with the ring
  johnson_slot_decode #(.STAGES(STAGES)) u_decode (
    .ring  (ring_d),
    .slots (slot_d)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ring_q  <= '0;
      slot_o  <= SLOTS'(1);
      carry_o <= 1'b1;
    end else if (!count_en_n) begin
      ring_q  <= ring_d;
      slot_o  <= slot_d;
      carry_o <= ~ring_d[STAGES-1];
    end
  end
endmodule

// File: rtl/johnson_divider_checks.sv
module johnson_divider_checks #(
  parameter int unsigned STAGES = 5,
  localparam int unsigned SLOTS = 2 * STAGES
) (
  input logic             clk,
  input logic             rst,
  input logic             count_en_n,
  input logic [SLOTS-1:0] slot_o,
  input logic             carry_o
);
  assert_one_slot_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_o) == 1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    count_en_n |=> ($stable(slot_o) && $stable(carry_o)));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    !count_en_n |=> slot_o == {$past(slot_o[SLOTS-2:0]), $past(slot_o[SLOTS-1])});

  assert_carry_half_R6: assert property (@(posedge clk) disable iff (rst)
    carry_o == (|slot_o[STAGES-1:0]));

  assert_carry_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_o) |-> slot_o[0]);
endmodule

bind johnson_divider johnson_divider_checks #(.STAGES(STAGES)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .count_en_n (count_en_n),
  .slot_o     (slot_o),
  .carry_o    (carry_o)
);

// File: tb/johnson_divider_bench.sv
module johnson_divider_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic count_en_n = 1'b1;
  logic [9:0] slot10;
  logic [7:0] slot8;
  logic carry10, carry8;
  logic [4:0] probe = '0;
  logic [4:0] probe_nx;
  int n_checks = 0;
  int n_err = 0;
  int idx10 = 0;
  int idx8 = 0;
  bit done = 0;

  always #5 clk = ~clk;

  johnson_divider #(.STAGES(5)) u_johnson_divider (
    .clk(clk), .rst(rst), .count_en_n(count_en_n), .slot_o(slot10), .carry_o(carry10));

  johnson_divider #(.STAGES(4)) u_div8 (
    .clk(clk), .rst(rst), .count_en_n(count_en_n), .slot_o(slot8), .carry_o(carry8));

  johnson_ring_step #(.STAGES(5)) u_step (.ring_q(probe), .ring_d(probe_nx));

  // reference position, kept from the requirements
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      idx10 <= 0;
      idx8  <= 0;
    end else if (!count_en_n) begin
      idx10 <= (idx10 + 1) % 10;
      idx8  <= (idx8 + 1) % 8;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(input int i);
    if (i < 5) return 5'((1 << i) - 1);
    return 5'(31 ^ ((1 << (i - 5)) - 1));
  endfunction

  function automatic bit legal5(input logic [4:0] w);
    for (int i = 0; i < 10; i++) if (code_of(i) == w) return 1;
    return 0;
  endfunction

  task automatic check_outputs(input string tag);
    chk({"R5 slots10 ", tag}, 32'(slot10), 32'(1) << idx10);
    chk({"R1 slots8 ", tag}, 32'(slot8), 32'(1) << idx8);
    chk({"R6 carry10 ", tag}, 32'(carry10), 32'(idx10 < 5));
    chk({"R6 carry8 ", tag}, 32'(carry8), 32'(idx8 < 4));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R5 watchdog: act=timeout exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [4:0] cur;
    logic [9:0] prev10;
    logic prev_c;
    void'($urandom(32'h5eed_0417));

    // R7: next-state logic on every ring pattern
    for (int s = 0; s < 32; s++) begin
      cur = 5'(s);
      for (int st = 0; st < 10 && !legal5(cur); st++) begin
        probe = cur;
        #1;
        cur = probe_nx;
      end
      chk("R7 recovery", 32'(legal5(cur)), 32'(1));
    end
    for (int i = 0; i < 10; i++) begin
      probe = code_of(i);
      #1;
      chk("R7 legal successor", 32'(probe_nx), 32'(code_of((i + 1) % 10)));
    end

    // R2: reset state, enable active during reset
    @(negedge clk);
    count_en_n = 1'b0;
    @(negedge clk);
    chk("R2 reset slots10", 32'(slot10), 32'(1));
    chk("R2 reset carry10", 32'(carry10), 32'(1));
    chk("R4 reset slots8", 32'(slot8), 32'(1));
    count_en_n = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R2 slot0 after release", 32'(slot10), 32'(1));

    // R1/R6: long enabled run, carry rises once per full count
    count_en_n = 1'b0;
    for (int c = 0; c < 25; c++) begin
      prev_c = carry10;
      @(negedge clk);
      check_outputs("run");
      if (!prev_c && carry10) chk("R6 carry rise at slot0", 32'(slot10), 32'(1));
    end

    // R3: long hold
    count_en_n = 1'b1;
    prev10 = slot10;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R3 hold", 32'(slot10), 32'(prev10));
    end

    // random enable with occasional asynchronous reset
    for (int c = 0; c < 600; c++) begin
      if ($urandom_range(0, 39) == 0) begin
        count_en_n = 1'b0;
        rst = 1'b1;
        #1;
        chk("R2 async clear", 32'(slot10), 32'(1));
        @(negedge clk);
        chk("R2 priority over enable", 32'(slot10), 32'(1));
        rst = 1'b0;
      end
      count_en_n = ($urandom_range(0, 3) == 0);
      @(negedge clk);
      check_outputs("random");
      chk("R4 onehot10", 32'($countones(slot10)), 32'(1));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule